// File: doc/BRIEF.md
# ECP Reverse-Channel Host Receiver

This block is the host end of the peripheral-to-host data path of an ECP-style parallel link. The peripheral offers a byte by pulling its clock line low. The host answers on its acknowledge line. The two lines are interlocked on both edges: the host raises its acknowledge line to take the byte, the peripheral raises its clock line in reply, and the host then drops its acknowledge line to close the transfer. The receiver runs through this exchange, latches each byte, and hands it downstream on a valid/ready stream.

The peripheral clock line is asynchronous. It passes through a multi-flop synchronizer, and its synchronized falling edge latches the data bus into a capture register. The host acknowledge stays low for as long as the downstream stream register is full and the sink is not ready. This holds the peripheral off. The byte enters the stream register on the same clock edge that drops the acknowledge line. If the peripheral never raises its clock line while the acknowledge is high, a timeout returns the receiver to idle, discards the byte and pulses an error output.

The controller has four states. IDLE waits for a falling edge of the synchronized line. HOLD has a byte latched and waits for stream space. ACK has the acknowledge line high and waits for the line to rise. FAULT is a one-cycle error state. The transitions are:
- IDLE→HOLD on a falling edge.
- HOLD→ACK when there is space.
- ACK→IDLE when the line is high, which pushes the byte.
- ACK→FAULT when the timeout expires.
- FAULT→IDLE unconditionally.

Top module: `ecp_rev_rx`

## Requirements
- R1: During and immediately after reset, `host_ack_o`, `byte_valid_o` and `timeout_err_o` are 0.
- R2: Each byte on `rev_data_i` when the synchronized `periph_clk_i` falls is delivered unchanged on `byte_data_o`. Bytes are delivered in the order they were offered.
- R3: With stream space free, `host_ack_o` rises exactly 4 clock cycles after `periph_clk_i` falls (2 synchronizer flops + edge detect + HOLD).
- R4: While `byte_valid_o` is 1 and `byte_ready_i` is 0, `host_ack_o` is not raised for a newly latched byte. It rises in the cycle after `byte_ready_i` goes to 1.
- R5: While `host_ack_o` is 1, a rise of `periph_clk_i` makes `host_ack_o` fall exactly 3 cycles later. `byte_valid_o` rises in that same cycle.
- R6: While `byte_valid_o` is 1 and `byte_ready_i` is 0, `byte_valid_o` stays 1 and `byte_data_o` is unchanged.
- R7: If `periph_clk_i` stays low for TIMEOUT_CYC cycles after `host_ack_o` rises, `host_ack_o` drops and `timeout_err_o` is 1 for exactly one cycle. The byte is discarded and `byte_valid_o` stays 0.
- R8: A transfer starts only from IDLE on a high-to-low change of `periph_clk_i` that was observed after reset or after the previous transfer. A line that is low at reset, or that stays low after a timeout, never raises `host_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rev_data_i | input | DATA_W | Data bus from the peripheral |
| periph_clk_i | input | 1 | Peripheral clock line, asynchronous; low means a byte is offered |
| host_ack_o | output | 1 | Host acknowledge line |
| byte_valid_o | output | 1 | Stream valid |
| byte_ready_i | input | 1 | Stream ready from the sink |
| byte_data_o | output | DATA_W | Stream data |
| timeout_err_o | output | 1 | One-cycle pulse when a transfer times out |

## Verification
Directed transfers with a ready sink pin down the exact latency of each edge of the handshake, in cycles. A sink that is held not-ready separates correct back-pressure, where the acknowledge is withheld and the data stays put, from a receiver that would overwrite or drop a byte. A clock line held low until the timeout, and held low from reset, tells a receiver that returns properly to idle apart from one that restarts on a level instead of an edge. Random bytes against a sink whose ready toggles at random check ordering and data integrity whenever stalls land on arbitrary cycles.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ACK   = 2'd2,
        ST_FAULT = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ecp_line_sync.sv
module ecp_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecp_rev_fsm.sv
module ecp_rev_fsm
    import ecp_rev_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_s_i,
    input  logic space_i,
    output logic host_ack_o,
    output logic capture_o,
    output logic push_o,
    output logic err_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    rx_state_e       state_q, state_d;
    logic            pclk_prev_q;
    logic [CW-1:0]   cnt_q;
    logic            line_fell;
    logic            expired;

    assign line_fell = pclk_prev_q && !pclk_s_i;
    assign expired   = (cnt_q == CW'(TIMEOUT_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (line_fell) state_d = ST_HOLD;
            ST_HOLD:  if (space_i)   state_d = ST_ACK;
            ST_ACK: begin
                if (pclk_s_i)     state_d = ST_IDLE;
                else if (expired) state_d = ST_FAULT;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pclk_prev_q <= 1'b0;
            cnt_q       <= '0;
        end else begin
            state_q     <= state_d;
            pclk_prev_q <= pclk_s_i;
            if (state_q == ST_ACK) cnt_q <= cnt_q + CW'(1);
            else                   cnt_q <= '0;
        end
    end

    always_comb begin
        host_ack_o = (state_q == ST_ACK);
        capture_o  = (state_q == ST_IDLE) && line_fell;
        push_o     = (state_q == ST_ACK) && pclk_s_i;
        err_o      = (state_q == ST_FAULT);
    end

    // R4: acknowledge only rises when the stream had room
    p_ack_needs_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack_o) |-> $past(space_i));

    // R7: acknowledge only falls after a push or into the error state
    p_ack_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ack_o) |-> ($past(push_o) || err_o));

    // R8: the data phase is entered from idle only
    p_enter_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |-> $past(state_q) == ST_IDLE);
endmodule

// File: rtl/ecp_rev_outbuf.sv
module ecp_rev_outbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              capture_i,
    input  logic              push_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              space_o
);
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (capture_i) cap_q <= data_i;
            if (push_i) begin
                data_q  <= cap_q;
                valid_q <= 1'b1;
            end else if (ready_i) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign space_o = !valid_q || ready_i;

    // R4: a push never lands on an occupied, stalled register
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!valid_q || ready_i));

    // R6: stalled data is held
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rev_data_i,
    input  logic              periph_clk_i,
    output logic              host_ack_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i,
    output logic [DATA_W-1:0] byte_data_o,
    output logic              timeout_err_o
);
    logic pclk_s;
    logic space;
    logic capture;
    logic push;

    ecp_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (periph_clk_i),
        .q_o   (pclk_s)
    );

    ecp_rev_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk_s_i   (pclk_s),
        .space_i    (space),
        .host_ack_o (host_ack_o),
        .capture_o  (capture),
        .push_o     (push),
        .err_o      (timeout_err_o)
    );

    ecp_rev_outbuf #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (rev_data_i),
        .capture_i (capture),
        .push_i    (push),
        .ready_i   (byte_ready_i),
        .valid_o   (byte_valid_o),
        .data_o    (byte_data_o),
        .space_o   (space)
    );

    // R5: a new stream byte appears exactly when the acknowledge drops
    p_push_with_ack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(byte_valid_o)) |-> $fell(host_ack_o));
endmodule

// File: tb/ecp_rev_rx_tb.sv
module ecp_rev_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pd = 8'h00;
    logic       pclk = 1'b0;
    logic       host_ack;
    logic       valid;
    logic       ready = 1'b0;
    logic [7:0] data;
    logic       err;

    int checks = 0;
    int fails  = 0;
    bit rand_mode = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecp_rev_rx #(.DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rev_data_i    (pd),
        .periph_clk_i  (pclk),
        .host_ack_o    (host_ack),
        .byte_valid_o  (valid),
        .byte_ready_i  (ready),
        .byte_data_o   (data),
        .timeout_err_o (err)
    );

    function automatic logic [7:0] next_byte(input int idx);
        return 8'((idx * 37 + 11) ^ $urandom_range(0, 255));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        pd = b;
        @(negedge clk);
        pclk = 1'b0;
        while (!host_ack) @(negedge clk);
        pclk = 1'b1;
        while (host_ack) @(negedge clk);
        pd = 8'($urandom_range(0, 255));
    endtask

    // random sink and scoreboard
    always @(negedge clk) begin
        if (rand_mode) begin
            ready = ($urandom_range(0, 2) != 0);
            if (valid && ready) begin
                if (exp_q.size() == 0) check("R2 unexpected byte", 32'(data), 32'hFFFF);
                else check("R2 data order", 32'(data), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1 / R8: line held low through reset
        cyc(3);
        check("R1 ack at reset", 32'(host_ack), 0);
        check("R1 valid at reset", 32'(valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", 32'(host_ack), 0);
        check("R1 err after reset", 32'(err), 0);
        cyc(10);
        check("R8 low line from reset no ack", 32'(host_ack), 0);
        pclk = 1'b1;
        cyc(5);

        // R3 / R5 / R2: exact latencies, sink stalled
        ready = 1'b0;
        pd = 8'hA5;
        pclk = 1'b0;
        cyc(3);
        check("R3 ack not yet", 32'(host_ack), 0);
        cyc(1);
        check("R3 ack after 4", 32'(host_ack), 1);
        pd = 8'h00;
        pclk = 1'b1;
        cyc(2);
        check("R5 ack still high", 32'(host_ack), 1);
        check("R5 valid not yet", 32'(valid), 0);
        cyc(1);
        check("R5 ack fell", 32'(host_ack), 0);
        check("R5 valid rose", 32'(valid), 1);
        check("R2 first byte", 32'(data), 32'hA5);

        // R4 / R6: back-pressure
        pd = 8'h3C;
        pclk = 1'b0;
        cyc(20);
        check("R4 ack withheld", 32'(host_ack), 0);
        check("R6 valid held", 32'(valid), 1);
        check("R6 data held", 32'(data), 32'hA5);
        ready = 1'b1;
        cyc(1);
        check("R4 ack after ready", 32'(host_ack), 1);
        check("R4 drained", 32'(valid), 0);
        ready = 1'b0;
        pclk = 1'b1;
        while (host_ack) @(negedge clk);
        check("R2 second byte", 32'(data), 32'h3C);
        ready = 1'b1;
        cyc(1);
        check("R6 drain", 32'(valid), 0);

        // R7 / R8: timeout
        cyc(3);
        pd = 8'h77;
        pclk = 1'b0;
        cyc(4);
        check("R7 ack up", 32'(host_ack), 1);
        cyc(TMO - 1);
        check("R7 ack still up", 32'(host_ack), 1);
        check("R7 no err yet", 32'(err), 0);
        cyc(1);
        check("R7 ack dropped", 32'(host_ack), 0);
        check("R7 err pulse", 32'(err), 1);
        cyc(1);
        check("R7 err one cycle", 32'(err), 0);
        check("R7 byte discarded", 32'(valid), 0);
        cyc(20);
        check("R8 stuck low no restart", 32'(host_ack), 0);
        pclk = 1'b1;
        cyc(6);
        check("R8 rise alone no ack", 32'(host_ack), 0);
        check("R7 still no byte", 32'(valid), 0);

        // R2 / R6: random bytes, random sink
        rand_mode = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b;
            b = next_byte(i);
            exp_q.push_back(b);
            send_byte(b);
            cyc($urandom_range(0, 4));
        end
        cyc(40);
        rand_mode = 1'b0;
        check("R2 all delivered", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule